// File: doc/BRIEF.md
# Outbound Address Window Translator

This block rewrites outbound request addresses through a bank of eight programmable windows. Each window holds a 64-bit match value, a 64-bit mask and a 64-bit remap base, together with a 32-bit action word that tells the downstream logic what kind of target the request is for (for example memory or I/O). Every request address is compared against all windows in parallel. The first enabled window that hits replaces the masked address bits with its remap base and supplies its action word.

Software programs the windows through a small word-addressed register port. Each window uses eight consecutive words. Bit 0 of a window's match-low word is its enable, so a window can be programmed completely before this bit is set by the final write. A separate global control word turns translation on or off for the whole bank. A bypass flag on a single request sends that request through unchanged. The result is registered and appears one cycle after the request.

Top module: `ob_addr_xlate`

## Requirements
- R1: After reset every configuration word reads as zero, the global enable is clear and `rsp_valid` is low.
- R2: A configuration read returns the last value written to that word, including the enable bit. Window w uses words `{w, off}` (window index in bits 5:3, offset in bits 2:0): offset 0 match low, 1 match high, 2 mask low, 3 mask high, 4 remap low, 5 remap high, 6 action. Any word with bit 6 set is the global control word, whose bit 0 is the global enable.
- R3: Window w hits when bit 0 of its match is set and `(addr & mask) == (match & mask)`, where bit 0 of the address is left out of the comparison.
- R4: On a hit the response address is `(remap & mask) | (addr & ~mask)`.
- R5: On a hit, `rsp_action` carries the hitting window's action word and `rsp_win` carries its index, with `rsp_miss` low.
- R6: When several windows hit, the lowest-numbered one is used.
- R7: While the global enable is clear, every request passes through with its address unchanged, action 0 (memory), window index 0 and `rsp_miss` high.
- R8: A request with `req_bypass` high passes through in the same way as in R7, even when a window matches.
- R9: A window whose enable bit is clear never hits, whatever its other fields hold. A request that no enabled window matches passes through as in R7.
- R10: `rsp_valid` and the response fields update on the clock edge that samples `req_valid` high, so the response appears exactly one cycle later. The response fields hold their value when no request is presented.
- R11: A write to offset 7 of a window block has no effect, and that word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Request address |
| req_bypass | input | 1 | Skip translation for this request |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_action | output | 32 | Action word of hitting window, 0 on miss |
| rsp_miss | output | 1 | No translation was applied |
| rsp_win | output | 3 | Index of hitting window, 0 on miss |

## Verification
Each window's state is visible at the ports in two places. It can be read back through the configuration port the moment after it is written. It also shapes the address and action of the next translated request. A corrupted match, mask or remap bit shows up as a wrong hit decision or a flipped output address bit one cycle after a request that crosses that bit. A broken enable or priority shows up as the wrong `rsp_win` or a false `rsp_miss` on that same response. The directed patterns are chosen so that overlapping windows, the ignored bit 0 and both disable paths each produce a response that differs from the correct one.

// File: rtl/ob_addr_xlate.sv
module ob_addr_xlate #(
  parameter int NWIN = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NWIN)+3:0] cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  input  logic                    req_valid,
  input  logic [63:0]             req_addr,
  input  logic                    req_bypass,
  output logic                    rsp_valid,
  output logic [63:0]             rsp_addr,
  output logic [31:0]             rsp_action,
  output logic                    rsp_miss,
  output logic [$clog2(NWIN)-1:0] rsp_win
);
  localparam int WIN_W = $clog2(NWIN);
  localparam int CA_W  = WIN_W + 4;

  logic [63:0] mt [NWIN];
  logic [63:0] mk [NWIN];
  logic [63:0] rm [NWIN];
  logic [31:0] act [NWIN];
  logic [31:0] glb;
  logic        gen_en;
  logic [NWIN-1:0] win_en, hit;

  wire             sel_glb = cfg_addr[CA_W-1];
  wire [WIN_W-1:0] sel_win = cfg_addr[CA_W-2:3];
  wire [2:0]       sel_off = cfg_addr[2:0];

  assign gen_en = glb[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        mt[i]  <= '0;
        mk[i]  <= '0;
        rm[i]  <= '0;
        act[i] <= '0;
      end
      glb <= '0;
    end else if (cfg_we) begin
      if (sel_glb) glb <= cfg_wdata;
      else begin
        case (sel_off)
          3'd0: mt[sel_win][31:0]  <= cfg_wdata;
          3'd1: mt[sel_win][63:32] <= cfg_wdata;
          3'd2: mk[sel_win][31:0]  <= cfg_wdata;
          3'd3: mk[sel_win][63:32] <= cfg_wdata;
          3'd4: rm[sel_win][31:0]  <= cfg_wdata;
          3'd5: rm[sel_win][63:32] <= cfg_wdata;
          3'd6: act[sel_win]       <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (sel_glb) cfg_rdata = glb;
    else begin
      case (sel_off)
        3'd0: cfg_rdata = mt[sel_win][31:0];
        3'd1: cfg_rdata = mt[sel_win][63:32];
        3'd2: cfg_rdata = mk[sel_win][31:0];
        3'd3: cfg_rdata = mk[sel_win][63:32];
        3'd4: cfg_rdata = rm[sel_win][31:0];
        3'd5: cfg_rdata = rm[sel_win][63:32];
        3'd6: cfg_rdata = act[sel_win];
        default: cfg_rdata = '0;
      endcase
    end
  end

  logic             found;
  logic [WIN_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int w = 0; w < NWIN; w++) begin
      win_en[w] = mt[w][0];
      hit[w] = win_en[w] &&
               (((req_addr ^ mt[w]) & mk[w] & ~64'h1) == 64'h0);
    end
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit[w]) begin
        found = 1'b1;
        pick  = WIN_W'(w);
      end
    end
  end

  wire        take = found && gen_en && !req_bypass;
  wire [63:0] xl   = (rm[pick] & mk[pick]) | (req_addr & ~mk[pick]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_action <= '0;
      rsp_miss   <= 1'b0;
      rsp_win    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr   <= take ? xl : req_addr;
        rsp_action <= take ? act[pick] : 32'h0;
        rsp_miss   <= !take;
        rsp_win    <= take ? pick : '0;
      end
    end
  end
endmodule

module ob_addr_xlate_chk #(
  parameter int NWIN = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [63:0]             req_addr,
  input logic                    req_bypass,
  input logic                    rsp_valid,
  input logic [63:0]             rsp_addr,
  input logic [31:0]             rsp_action,
  input logic                    rsp_miss,
  input logic [$clog2(NWIN)-1:0] rsp_win,
  input logic                    gen_en,
  input logic [NWIN-1:0]         win_en
);
  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bypass) |=> (rsp_miss && rsp_addr == $past(req_addr)));

  // R7
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !gen_en) |=> (rsp_miss && rsp_addr == $past(req_addr)));

  // R7
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_action == 32'h0 && rsp_win == '0));

  // R9
  none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_en == '0) |=> rsp_miss);
endmodule

bind ob_addr_xlate ob_addr_xlate_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_bypass(req_bypass), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .rsp_action(rsp_action), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
  .gen_en(gen_en), .win_en(win_en)
);

// File: tb/ob_addr_xlate_tb.sv
module ob_addr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_bypass = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_action;
  logic        rsp_miss;
  logic [2:0]  rsp_win;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ob_addr_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_bypass(req_bypass), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_action(rsp_action), .rsp_miss(rsp_miss),
    .rsp_win(rsp_win)
  );

  function automatic logic [6:0] wa(input int w, input int off);
    return {1'b0, 3'(w), 3'(off)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic prog(input int w, input logic [63:0] m, input logic [63:0] k,
                      input logic [63:0] r, input logic [31:0] a, input bit en);
    wr(wa(w, 1), m[63:32]);
    wr(wa(w, 2), k[31:0]);
    wr(wa(w, 3), k[63:32]);
    wr(wa(w, 4), r[31:0]);
    wr(wa(w, 5), r[63:32]);
    wr(wa(w, 6), a);
    wr(wa(w, 0), {m[31:1], en});
  endtask

  task automatic xlate(input string req, input logic [63:0] a, input bit byp,
                       input logic [63:0] ea, input logic [31:0] eact,
                       input bit emiss, input logic [2:0] ewin);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_bypass = byp;
    @(negedge clk);
    req_valid = 1'b0; req_bypass = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " addr"}, rsp_addr, ea);
    chk({req, " action"}, 64'(rsp_action), 64'(eact));
    chk({req, " miss"}, 64'(rsp_miss), 64'(emiss));
    chk({req, " win"}, 64'(rsp_win), 64'(ewin));
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    rd_chk("R1 match lo", wa(0, 0), 32'h0);
    rd_chk("R1 mask hi", wa(7, 3), 32'h0);
    rd_chk("R1 global", 7'h40, 32'h0);
  endtask

  task automatic t_readback;
    prog(3, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000,
         64'h0BAD_F00D_CAFE_0000, 32'h0000_0004, 1'b1);
    rd_chk("R2 match lo", wa(3, 0), 32'h9ABC_DEF1);
    rd_chk("R2 match hi", wa(3, 1), 32'h1234_5678);
    rd_chk("R2 mask lo", wa(3, 2), 32'hFFFF_0000);
    rd_chk("R2 remap hi", wa(3, 5), 32'h0BAD_F00D);
    rd_chk("R2 action", wa(3, 6), 32'h0000_0004);
    wr(wa(3, 0), 32'h0);
    rd_chk("R2 match lo cleared", wa(3, 0), 32'h0);
  endtask

  task automatic t_reserved;
    wr(wa(2, 7), 32'hDEAD_BEEF);
    rd_chk("R11 reserved word", wa(2, 7), 32'h0);
    rd_chk("R11 neighbour action", wa(2, 6), 32'h0);
  endtask

  task automatic t_global_off;
    xlate("R7 global off", 64'h1_2345_6789, 1'b0, 64'h1_2345_6789, 32'h0, 1'b1, 3'd0);
  endtask

  task automatic t_basic;
    wr(7'h40, 32'h1);
    rd_chk("R2 global", 7'h40, 32'h1);
    xlate("R4 mem window", 64'h1_2345_6789, 1'b0, 64'h0_8345_6789, 32'h0, 1'b0, 3'd0);
    xlate("R5 io window", 64'h4000_1234, 1'b0, 64'hAB_0000_1234, 32'h4, 1'b0, 3'd1);
    xlate("R9 no match", 64'h7777_0000, 1'b0, 64'h7777_0000, 32'h0, 1'b1, 3'd0);
  endtask

  task automatic t_priority;
    xlate("R6 overlap low wins", 64'h1_2000_0010, 1'b0, 64'h0_8000_0010, 32'h0, 1'b0, 3'd0);
    wr(wa(0, 0), 32'h2000_0000);
    xlate("R6 high after low off", 64'h1_2000_0010, 1'b0, 64'h9000_0010, 32'h4, 1'b0, 3'd2);
    wr(wa(0, 0), 32'h2000_0001);
  endtask

  task automatic t_bit0;
    xlate("R3 bit0 clear", 64'h5000_0000, 1'b0, 64'h6000_0000, 32'h0, 1'b0, 3'd4);
    xlate("R3 bit0 set", 64'h5000_0001, 1'b0, 64'h6000_0000, 32'h0, 1'b0, 3'd4);
    xlate("R3 bit1 differs", 64'h5000_0002, 1'b0, 64'h5000_0002, 32'h0, 1'b1, 3'd0);
  endtask

  task automatic t_disabled;
    xlate("R9 window off", 64'hA000_0004, 1'b0, 64'hA000_0004, 32'h0, 1'b1, 3'd0);
    wr(wa(6, 0), 32'hA000_0001);
    xlate("R9 window on", 64'hA000_0004, 1'b0, 64'hC000_0004, 32'h4, 1'b0, 3'd6);
  endtask

  task automatic t_bypass;
    xlate("R8 bypass", 64'h1_2345_6789, 1'b1, 64'h1_2345_6789, 32'h0, 1'b1, 3'd0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h4000_0008;
    #1;
    chk("R10 not yet valid", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 64'h1_2000_0000;
    chk("R10 valid after edge", 64'(rsp_valid), 64'd1);
    chk("R10 addr after edge", rsp_addr, 64'hAB_0000_0008);
    @(negedge clk);
    chk("R10 valid drops", 64'(rsp_valid), 64'd0);
    chk("R10 addr holds", rsp_addr, 64'hAB_0000_0008);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_reserved();
    prog(0, 64'h1_2000_0000, 64'hFFFF_FFFF_F000_0000, 64'h8000_0000, 32'h0, 1'b1);
    prog(1, 64'h4000_0000, 64'hFFFF_FFFF_FFFF_0000, 64'hAB_0000_0000, 32'h4, 1'b1);
    prog(2, 64'h1_2000_0000, 64'hFFFF_FFFF_FF00_0000, 64'h9000_0000, 32'h4, 1'b1);
    prog(4, 64'h5000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h6000_0000, 32'h0, 1'b1);
    prog(6, 64'hA000_0000, 64'hFFFF_FFFF_F000_0000, 64'hC000_0000, 32'h4, 1'b0);
    t_global_off();
    t_basic();
    t_priority();
    t_bit0();
    t_disabled();
    t_bypass();
    t_latency();
    finish_run();
  end
endmodule